// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block is the read engine on the memory side of a clocked parallel read port. A host writes a 16-bit read-setup word, then presents a start address together with a one-cycle address strobe. In synchronous mode the sequencer counts a programmable first-access latency. It then streams one word per clock from a small internal array, walking the addresses either linearly or inside a burst-aligned wrap window. It drives a WAIT line whose polarity, and whose release one cycle ahead of the first data, are both programmable.

In page mode the strobe instead captures a 16-word page from the array into a page buffer. From the next cycle on, the low four address bits pick the word on the data bus combinationally, with no latency and no WAIT activity. Chip enable going low aborts whatever is in progress. The array is filled through a dedicated write port, which a surrounding model or bench uses to load content.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset, data_ok is 0, rd_data is 0, cfg_err is 0 and wait_out sits at its inactive level. The reset setup word is 0x240F: synchronous mode, latency 4, WAIT active-high, no early WAIT, linear order, continuous length.
- R2: The setup word is decoded as follows. Bit 15 selects page mode. Bits 14:11 hold the latency, bit 10 the WAIT polarity, bit 8 the early-WAIT option, bit 3 linear order, and bits 2:0 the length code. The length codes are 1=4 words, 2=8, 3=16 and 7=continuous. cfg_err is 1 when the latency is 0 or 1, the length code is any other value, or any of bits 9 or 7:4 is set. While cfg_err is 1, a strobe starts no burst: data_ok stays 0 and WAIT stays inactive.
- R3: A burst is started by a strobe with chip_en high. The first word appears with data_ok=1 exactly latency clock edges after the edge that latched the address. rd_data holds the array word at cur_addr.
- R4: A fixed-length burst delivers exactly 4, 8 or 16 words on consecutive clocks. data_ok then falls.
- R5: With bit 3 clear and a fixed length N, word k of the burst comes from (start & ~(N-1)) | ((start+k) mod N).
- R6: With bit 3 set, word k comes from (start+k) mod 2^ADDR_W, so the addresses cross window boundaries and the top of the array.
- R7: A continuous burst always advances linearly, even with bit 3 clear, and never ends while chip_en stays high.
- R8: wait_out is high when active if bit 10 is 1, and low when active if bit 10 is 0. It is at its inactive level whenever no latency phase is under way, including while data is being delivered.
- R9: With bit 8 clear, WAIT is active for exactly the latency cycles before the first word. With bit 8 set, it is active for one cycle fewer and releases one cycle before the first word.
- R10: In page mode, a strobe loads the 16-word page that holds addr_in. From the next cycle on, data_ok is 1 and rd_data is the word at {loaded page, addr_in[3:0]}. That word follows addr_in[3:0] within the same cycle, no strobe is needed to change it, and WAIT is inactive.
- R11: chip_en low ends any burst or page. From the next cycle on, data_ok is 0, rd_data is 0 and WAIT is inactive. Strobes are ignored while chip_en is low.
- R12: A strobe during a burst abandons it and starts a new one from the new address, with the full latency counted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the setup word |
| cfg_wdata | input | 16 | Setup word value |
| fill_we | input | 1 | Array fill write enable |
| fill_addr | input | ADDR_W | Array fill address |
| fill_data | input | DATA_W | Array fill data |
| chip_en | input | 1 | Active-high select; low aborts everything |
| adr_strobe | input | 1 | Latches addr_in and starts a burst or page load |
| addr_in | input | ADDR_W | Start address; low 4 bits select the page word |
| rd_data | output | DATA_W | Delivered word, 0 when nothing is valid |
| data_ok | output | 1 | rd_data holds a valid word |
| cur_addr | output | ADDR_W | Array address of the word on rd_data |
| wait_out | output | 1 | Programmable-polarity WAIT |
| cfg_err | output | 1 | Setup word holds an illegal field |

## Verification
A wrong latency counter or start decision shows at the ports within one burst. The first data_ok edge moves off the latency count, and the WAIT release moves with it. A faulty address step shows as a wrong cur_addr and rd_data pair on the first beat that crosses a wrap boundary or the array top. A beat counter error shows as data_ok staying high, or dropping, one clock away from the N-th word. Page-buffer or deselect faults appear within one cycle on the combinational page read or on the first cycle after chip_en falls.

// File: rtl/brs_pkg.sv
package brs_pkg;

    localparam int CFG_W = 16;

    // Setup word layout, most significant field first
    typedef struct packed {
        logic       page_mode;   // 15
        logic [3:0] lat;         // 14:11
        logic       wait_hi;     // 10
        logic       rsv_a;       // 9
        logic       wait_early;  // 8
        logic [3:0] rsv_b;       // 7:4
        logic       linear;      // 3
        logic [2:0] bl;          // 2:0
    } rd_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAT  = 2'd1,
        ST_DATA = 2'd2
    } bst_t;

    localparam logic [CFG_W-1:0] CFG_RESET = 16'h240F;

    localparam logic [2:0] BL_4    = 3'd1;
    localparam logic [2:0] BL_8    = 3'd2;
    localparam logic [2:0] BL_16   = 3'd3;
    localparam logic [2:0] BL_CONT = 3'd7;

    localparam logic [3:0] LAT_MIN = 4'd2;

    // Words per fixed burst; 0 stands for an unbounded burst
    function automatic logic [4:0] burst_words(input logic [2:0] bl);
        case (bl)
            BL_4:    return 5'd4;
            BL_8:    return 5'd8;
            BL_16:   return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic bl_legal(input logic [2:0] bl);
        return (bl == BL_4) || (bl == BL_8) || (bl == BL_16) || (bl == BL_CONT);
    endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
    import brs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic             page_mode,
    output logic [3:0]       lat,
    output logic             wait_hi,
    output logic             wait_early,
    output logic             linear,
    output logic [2:0]       bl,
    output logic             cfg_err
);

    rd_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= rd_cfg_t'(CFG_RESET);
        end else if (we) begin
            cfg_q <= rd_cfg_t'(wdata);
        end
    end

    assign page_mode  = cfg_q.page_mode;
    assign lat        = cfg_q.lat;
    assign wait_hi    = cfg_q.wait_hi;
    assign wait_early = cfg_q.wait_early;
    assign linear     = cfg_q.linear;
    assign bl         = cfg_q.bl;

    assign cfg_err = (cfg_q.lat < LAT_MIN) || !bl_legal(cfg_q.bl)
                   || cfg_q.rsv_a || (cfg_q.rsv_b != 4'd0);

endmodule

// File: rtl/brs_array.sv
module brs_array #(
    parameter  int ADDR_W = 8,
    parameter  int DATA_W = 16,
    parameter  int PAGE_W = 4,
    localparam int TAG_W  = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [ADDR_W-1:0] rd_ptr,
    output logic [DATA_W-1:0] rd_word,
    input  logic              page_load,
    input  logic [TAG_W-1:0]  page_base,
    input  logic              page_drop,
    input  logic [PAGE_W-1:0] page_sel,
    output logic [DATA_W-1:0] page_word,
    output logic              page_vld,
    output logic [TAG_W-1:0]  page_tag
);

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_WORDS = 1 << PAGE_W;

    logic [DATA_W-1:0] mem  [DEPTH];
    logic [DATA_W-1:0] pbuf [PAGE_WORDS];

    always_ff @(posedge clk) begin
        if (fill_we) begin
            mem[fill_addr] <= fill_data;
        end
    end

    assign rd_word = mem[rd_ptr];

    // Whole page captured in one edge
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= '0;
        end else if (page_load) begin
            for (int i = 0; i < PAGE_WORDS; i++) pbuf[i] <= mem[{page_base, PAGE_W'(i)}];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || page_drop) begin
            page_vld <= 1'b0;
            page_tag <= '0;
        end else if (page_load) begin
            page_vld <= 1'b1;
            page_tag <= page_base;
        end
    end

    assign page_word = pbuf[page_sel];

endmodule

// File: rtl/brs_burst_ctl.sv
module brs_burst_ctl
    import brs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              strobe,
    input  logic              start_ok,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [3:0]        lat,
    input  logic [2:0]        bl,
    input  logic              linear,
    output logic [ADDR_W-1:0] rd_ptr,
    input  logic [DATA_W-1:0] rd_word,
    output logic              data_vld,
    output logic [DATA_W-1:0] data_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              in_lat,
    output logic              lat_last
);

    bst_t              st_q;
    logic [3:0]        cnt_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [4:0]        beats_q;
    logic [4:0]        len_q;
    logic              lin_q;
    logic [ADDR_W-1:0] wmask;
    logic [ADDR_W-1:0] ptr_inc;
    logic [ADDR_W-1:0] ptr_nxt;
    logic              last_beat;

    assign wmask     = ADDR_W'(len_q - 5'd1);
    assign ptr_inc   = ptr_q + ADDR_W'(1);
    assign ptr_nxt   = lin_q ? ptr_inc : ((ptr_q & ~wmask) | (ptr_inc & wmask));
    assign last_beat = (len_q != 5'd0) && (beats_q == len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            ptr_q    <= '0;
            beats_q  <= '0;
            len_q    <= '0;
            lin_q    <= 1'b1;
            data_vld <= 1'b0;
            data_q   <= '0;
            addr_q   <= '0;
        end else if (!chip_en) begin
            st_q     <= ST_IDLE;
            data_vld <= 1'b0;
            data_q   <= '0;
            addr_q   <= '0;
        end else if (strobe) begin
            data_vld <= 1'b0;
            data_q   <= '0;
            addr_q   <= '0;
            if (start_ok) begin
                st_q    <= ST_LAT;
                cnt_q   <= lat - 4'd1;
                ptr_q   <= addr_in;
                beats_q <= '0;
                len_q   <= burst_words(bl);
                lin_q   <= linear || (bl == BL_CONT);
            end else begin
                st_q <= ST_IDLE;
            end
        end else begin
            case (st_q)
                ST_LAT: begin
                    if (cnt_q == 4'd0) begin
                        st_q     <= ST_DATA;
                        data_vld <= 1'b1;
                        data_q   <= rd_word;
                        addr_q   <= ptr_q;
                        ptr_q    <= ptr_nxt;
                        beats_q  <= 5'd1;
                    end else begin
                        cnt_q <= cnt_q - 4'd1;
                    end
                end
                ST_DATA: begin
                    if (last_beat) begin
                        st_q     <= ST_IDLE;
                        data_vld <= 1'b0;
                        data_q   <= '0;
                        addr_q   <= '0;
                    end else begin
                        data_q  <= rd_word;
                        addr_q  <= ptr_q;
                        ptr_q   <= ptr_nxt;
                        if (len_q != 5'd0) beats_q <= beats_q + 5'd1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign rd_ptr   = ptr_q;
    assign in_lat   = (st_q == ST_LAT);
    assign lat_last = (st_q == ST_LAT) && (cnt_q == 4'd0);

    AST_BLOCKED_START: assert property (@(posedge clk) disable iff (rst)
        (chip_en && strobe && !start_ok) |=> (st_q == ST_IDLE && !data_vld)); // R2

    AST_FIRST_AFTER_LAT: assert property (@(posedge clk) disable iff (rst)
        $rose(data_vld) |-> $past(st_q == ST_LAT)); // R3

    AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (data_vld && len_q != 5'd0) |-> (beats_q <= len_q)); // R4

    AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (data_vld && $past(data_vld) && !lin_q)
        |-> ((addr_q & ~wmask) == ($past(addr_q) & ~wmask))); // R5

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> (st_q == ST_IDLE && !data_vld && data_q == '0)); // R11

endmodule

// File: rtl/brs_wait_gen.sv
module brs_wait_gen (
    input  logic in_lat,
    input  logic lat_last,
    input  logic page_mode,
    input  logic wait_hi,
    input  logic wait_early,
    output logic wait_out
);

    logic active;

    always_comb begin
        if (page_mode) begin
            active = 1'b0;
        end else if (wait_early) begin
            active = in_lat && !lat_last;
        end else begin
            active = in_lat;
        end
    end

    assign wait_out = active ? wait_hi : !wait_hi;

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import brs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              chip_en,
    input  logic              adr_strobe,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_ok,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              wait_out,
    output logic              cfg_err
);

    localparam int TAG_W = ADDR_W - PAGE_W;

    logic              pg_mode;
    logic [3:0]        lat;
    logic              wait_hi;
    logic              wait_early;
    logic              linear;
    logic [2:0]        bl;

    logic [ADDR_W-1:0] rd_ptr;
    logic [DATA_W-1:0] rd_word;
    logic              b_vld;
    logic [DATA_W-1:0] b_data;
    logic [ADDR_W-1:0] b_addr;
    logic              in_lat;
    logic              lat_last;

    logic [DATA_W-1:0] pg_word;
    logic              pg_vld;
    logic [TAG_W-1:0]  pg_tag;
    logic              pg_load;

    brs_cfg_reg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .page_mode  (pg_mode),
        .lat        (lat),
        .wait_hi    (wait_hi),
        .wait_early (wait_early),
        .linear     (linear),
        .bl         (bl),
        .cfg_err    (cfg_err)
    );

    assign pg_load = chip_en && adr_strobe && pg_mode;

    brs_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .fill_we   (fill_we),
        .fill_addr (fill_addr),
        .fill_data (fill_data),
        .rd_ptr    (rd_ptr),
        .rd_word   (rd_word),
        .page_load (pg_load),
        .page_base (addr_in[ADDR_W-1:PAGE_W]),
        .page_drop (!chip_en || cfg_we),
        .page_sel  (addr_in[PAGE_W-1:0]),
        .page_word (pg_word),
        .page_vld  (pg_vld),
        .page_tag  (pg_tag)
    );

    brs_burst_ctl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .chip_en  (chip_en),
        .strobe   (adr_strobe),
        .start_ok (!cfg_err && !pg_mode),
        .addr_in  (addr_in),
        .lat      (lat),
        .bl       (bl),
        .linear   (linear),
        .rd_ptr   (rd_ptr),
        .rd_word  (rd_word),
        .data_vld (b_vld),
        .data_q   (b_data),
        .addr_q   (b_addr),
        .in_lat   (in_lat),
        .lat_last (lat_last)
    );

    brs_wait_gen u_wait (
        .in_lat     (in_lat),
        .lat_last   (lat_last),
        .page_mode  (pg_mode),
        .wait_hi    (wait_hi),
        .wait_early (wait_early),
        .wait_out   (wait_out)
    );

    always_comb begin
        if (pg_mode) begin
            data_ok  = pg_vld;
            rd_data  = pg_vld ? pg_word : '0;
            cur_addr = pg_vld ? {pg_tag, addr_in[PAGE_W-1:0]} : '0;
        end else begin
            data_ok  = b_vld;
            rd_data  = b_data;
            cur_addr = b_addr;
        end
    end

    AST_NO_WAIT_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        (data_ok && !pg_mode) |-> (wait_out == !wait_hi)); // R8

    AST_PAGE_WAIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (pg_mode && pg_vld) |-> (wait_out == !wait_hi)); // R10

endmodule

// File: tb/burst_rd_seq_bench.sv
module burst_rd_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [15:0]   cfg_wdata;
    logic          fill_we;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_data;
    logic          chip_en;
    logic          adr_strobe;
    logic [AW-1:0] addr_in;
    logic [DW-1:0] rd_data;
    logic          data_ok;
    logic [AW-1:0] cur_addr;
    logic          wait_out;
    logic          cfg_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_rd_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(4)) u_burst_rd_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .fill_we    (fill_we),
        .fill_addr  (fill_addr),
        .fill_data  (fill_data),
        .chip_en    (chip_en),
        .adr_strobe (adr_strobe),
        .addr_in    (addr_in),
        .rd_data    (rd_data),
        .data_ok    (data_ok),
        .cur_addr   (cur_addr),
        .wait_out   (wait_out),
        .cfg_err    (cfg_err)
    );

    function automatic logic [15:0] mem_val(input int a);
        return 16'(a * 291) ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] mk(input int pg, input int lat, input int whi,
                                       input int wearly, input int lin, input int bl);
        return {1'(pg), 4'(lat), 1'(whi), 1'b0, 1'(wearly), 4'b0000, 1'(lin), 3'(bl)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic strobe(input int a);
        adr_strobe = 1'b1;
        addr_in    = AW'(a);
        @(negedge clk);
        adr_strobe = 1'b0;
    endtask

    // Cycle j = 0 is the cycle right after the latching edge
    task automatic check_seq(input int start, input int lat, input int n, input int lin,
                             input int whi, input int wearly, input int cycles);
        for (int j = 0; j < cycles; j++) begin
            bit exp_v;
            bit wact;
            int k;
            int ea;
            exp_v = (j >= lat) && ((n == 0) || (j < lat + n));
            wact  = wearly ? (j < lat - 1) : (j < lat);
            chk("R3 R4 data_ok timing", 32'(data_ok), 32'(exp_v));
            chk(wearly ? "R9 early WAIT" : "R9 R8 WAIT window", 32'(wait_out),
                32'(wact ? whi : 1 - whi));
            if (exp_v) begin
                k = j - lat;
                if (lin != 0 || n == 0) ea = (start + k) & 255;
                else ea = (start & ~(n - 1)) | ((start + k) & (n - 1));
                chk(n == 0 ? "R7 continuous address" : (lin != 0 ? "R6 linear address" : "R5 wrap address"),
                    32'(cur_addr), 32'(ea));
                chk("R3 word data", 32'(rd_data), 32'(mem_val(ea)));
            end
            @(negedge clk);
        end
    endtask

    task automatic run_burst(input int start, input int lat, input int bl, input int lin,
                             input int whi, input int wearly);
        int n;
        n = (bl == 1) ? 4 : (bl == 2) ? 8 : 16;
        write_cfg(mk(0, lat, whi, wearly, lin, bl));
        strobe(start);
        check_seq(start, lat, n, lin, whi, wearly, lat + n + 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst        = 1'b1;
        cfg_we     = 1'b0;
        cfg_wdata  = '0;
        fill_we    = 1'b0;
        fill_addr  = '0;
        fill_data  = '0;
        chip_en    = 1'b0;
        adr_strobe = 1'b0;
        addr_in    = '0;
        @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            fill_we   = 1'b1;
            fill_addr = AW'(a);
            fill_data = mem_val(a);
            @(negedge clk);
        end
        fill_we = 1'b0;
        rst     = 1'b0;
        chip_en = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 data_ok", 32'(data_ok), 0);
        chk("R1 rd_data", 32'(rd_data), 0);
        chk("R1 cfg_err", 32'(cfg_err), 0);
        chk("R1 wait inactive", 32'(wait_out), 0);

        // R1 reset setup: latency 4, continuous, active-high WAIT
        strobe(8'h20);
        check_seq(8'h20, 4, 0, 1, 1, 0, 10);
        chip_en = 1'b0;
        @(negedge clk);
        chip_en = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6 R8 R9 sweep over latency, length, order
        for (int lat = 2; lat < 16; lat++) begin
            for (int bl = 1; bl <= 3; bl++) begin
                for (int lin = 0; lin < 2; lin++) begin
                    int s;
                    s = (lat * 37 + bl * 11 + lin * 5) & 255;
                    run_burst(s, lat, bl, lin, lat & 1, ((lat >> 1) ^ lin) & 1);
                    run_burst(s ^ 8'hA7, lat, bl, lin, 1 - (lat & 1), (lat >> 1) & 1);
                end
            end
        end

        // R6 linear run across the array top
        run_burst(8'hFE, 3, 3, 1, 1, 0);
        // R5 wrap at the window top
        run_burst(8'h7F, 2, 3, 0, 0, 1);

        // R7 continuous with wrap bit clear stays linear
        write_cfg(mk(0, 3, 1, 0, 0, 7));
        strobe(8'hF0);
        check_seq(8'hF0, 3, 0, 0, 1, 0, 43);
        // R11 deselect ends it
        chip_en = 1'b0;
        @(negedge clk);
        chk("R11 data_ok after deselect", 32'(data_ok), 0);
        chk("R11 rd_data after deselect", 32'(rd_data), 0);
        chk("R11 wait after deselect", 32'(wait_out), 0);
        // R11 strobe ignored while deselected
        strobe(8'h10);
        for (int j = 0; j < 6; j++) begin
            chk("R11 strobe ignored data_ok", 32'(data_ok), 0);
            chk("R11 strobe ignored wait", 32'(wait_out), 0);
            if (j == 2) chip_en = 1'b1;
            @(negedge clk);
        end

        // R11 deselect during latency
        write_cfg(mk(0, 6, 0, 0, 1, 2));
        strobe(8'h40);
        chk("R11 wait active in latency", 32'(wait_out), 0);
        @(negedge clk);
        chip_en = 1'b0;
        @(negedge clk);
        chk("R11 wait released on deselect", 32'(wait_out), 1);
        chip_en = 1'b1;
        for (int j = 0; j < 8; j++) begin
            chk("R11 no data after aborted burst", 32'(data_ok), 0);
            @(negedge clk);
        end

        // R12 restart mid-burst
        write_cfg(mk(0, 4, 1, 0, 0, 2));
        strobe(8'h10);
        repeat (6) @(negedge clk);
        chk("R12 first burst delivering", 32'(data_ok), 1);
        strobe(8'h85);
        check_seq(8'h85, 4, 8, 0, 1, 0, 14);

        // R2 illegal setups block bursts
        for (int e = 0; e < 4; e++) begin
            logic [15:0] v;
            case (e)
                0: v = mk(0, 1, 1, 0, 1, 2);
                1: v = mk(0, 0, 1, 0, 1, 1);
                2: v = mk(0, 4, 1, 0, 1, 4);
                default: v = mk(0, 4, 1, 0, 1, 2) | 16'h0020;
            endcase
            write_cfg(v);
            chk("R2 cfg_err set", 32'(cfg_err), 1);
            strobe(8'h33);
            for (int j = 0; j < 8; j++) begin
                chk("R2 no burst data", 32'(data_ok), 0);
                chk("R2 WAIT stays inactive", 32'(wait_out), 0);
                @(negedge clk);
            end
        end
        write_cfg(mk(0, 2, 1, 0, 1, 7));
        chk("R2 cfg_err clear", 32'(cfg_err), 0);

        // R10 page mode
        write_cfg(mk(1, 4, 0, 0, 0, 7));
        strobe(8'h6A);
        for (int o = 0; o < 16; o++) begin
            addr_in = AW'(8'h60 + o);
            #1;
            chk("R10 page data_ok", 32'(data_ok), 1);
            chk("R10 page word", 32'(rd_data), 32'(mem_val(8'h60 + o)));
            chk("R10 page address", 32'(cur_addr), 32'(8'h60 + o));
            chk("R10 page wait inactive", 32'(wait_out), 1);
        end
        addr_in = 8'h35;
        #1;
        chk("R10 page held without strobe", 32'(rd_data), 32'(mem_val(8'h65)));
        @(negedge clk);
        strobe(8'h35);
        addr_in = 8'h3C;
        #1;
        chk("R10 new page word", 32'(rd_data), 32'(mem_val(8'h3C)));
        @(negedge clk);
        chip_en = 1'b0;
        @(negedge clk);
        chk("R11 page dropped on deselect", 32'(data_ok), 0);
        chk("R11 page data cleared", 32'(rd_data), 0);
        chip_en = 1'b1;
        @(negedge clk);

        summary();
        $finish;
    end

endmodule